// File: doc/BRIEF.md
# Genlock serial word transmitter

This block sends a subcarrier oscillator frequency control word over one serial line, once per video line, so that a slave device can lock its own colour oscillator to the local one. It runs on the system clock and moves one bit per clock. A transmission starts on a line strobe, and only after the line has been idle for a minimum gap. The frame is a high start bit, then the 23-bit word most significant bit first, then a run of guard clocks, then a single phase-reset slot.

The phase-reset slot is active low. A host write pulse arms a reset request. The request is carried by the next frame that starts after the write. In that frame the slot is driven low, and the block pulses a local output in the same cycle so the local oscillator phase can be cleared together with the slave's. The request is cleared once its slot has gone out. The control word is copied into a shadow register when a frame starts, so the caller may change it at any time.

Top module: `glk_serial_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, the serial line and the phase-zero pulse are both 0.
- R2: A line strobe that is accepted on a clock edge makes the next cycle a start bit: the serial line is 1 for exactly that one cycle and the phase-zero pulse is 0.
- R3: In the 23 cycles after the start bit, the line carries the control word, most significant bit (bit 22) first and one bit per cycle. The last of these cycles, which carries bit 0, is always driven 0 whatever the input bit 0 is.
- R4: The control word is sampled on the edge that accepts the strobe. Changes to the word input later in the frame do not alter the bits sent.
- R5: After bit 0 the line is driven 1 for 7 guard cycles. The reset slot follows, 8 cycles after the bit-0 cycle, and the whole frame lasts 32 cycles.
- R6: In the reset slot the line is 0 and the phase-zero pulse is 1 for that single cycle if a reset is armed for this frame. Otherwise the line is 1 in the slot and the pulse stays 0.
- R7: A strobe is accepted only once the line has been idle for at least 129 consecutive cycles, counted from the end of reset or from the cycle after a reset slot. A strobe seen earlier is ignored and starts no frame.
- R8: A host request pulse given while no frame is running arms a reset for the next frame. After its slot has been sent, the request is cleared, and the frame after that carries no reset.
- R9: A host request pulse given during a frame, including the reset-slot cycle of an armed frame, does not affect that frame and arms the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 23 | Oscillator frequency control word |
| line_strobe | input | 1 | Start-of-line request for a frame |
| phase_req | input | 1 | Host write pulse that arms a phase reset |
| ser_o | output | 1 | Serial genlock line |
| phase_zero_o | output | 1 | One-cycle pulse when the reset slot is sent active |

## Verification
The delicate coincidence is a host request that lands in the very cycle an armed reset slot is being sent. In that cycle the clearing of the current request and the recording of the new one compete for the same state. The bench raises the request pulse exactly in the slot cycle of an armed frame. It then expects that slot to go low with the pulse set, the next frame to carry a reset again, and the frame after that to carry none. A request raised mid-word, and strobes held for one cycle short of the idle gap, are judged the same way at the line.

// File: rtl/glk_pkg.sv
package glk_pkg;

   // Segment of a frame the sequencer is currently in
   typedef enum logic [1:0] {
      SEG_START = 2'd0,
      SEG_DATA  = 2'd1,
      SEG_GUARD = 2'd2,
      SEG_SLOT  = 2'd3
   } seg_e;

   // Total frame length in cycles: start + word + guard + slot
   function automatic int frame_len(input int word_w, input int rst_dly);
      return 1 + word_w + rst_dly;
   endfunction

endpackage

// File: rtl/glk_gap_timer.sv
module glk_gap_timer #(
   parameter int GAP_CYC = 128
) (
   input  logic clk,
   input  logic rst,
   input  logic busy,
   output logic ready
);
   localparam int CNT_W = $clog2(GAP_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(GAP_CYC);

   logic [CNT_W-1:0] idle_cnt;

   generate
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("glk_gap_timer: GAP_CYC must be at least 1");
      end
   endgenerate

   // Counts idle cycles since the last frame; held at zero while busy
   always_ff @(posedge clk) begin
      if (rst || busy) begin
         idle_cnt <= '0;
      end else if (idle_cnt != CNT_MAX) begin
         idle_cnt <= idle_cnt + CNT_W'(1);
      end
   end

   assign ready = !busy && (idle_cnt == CNT_MAX);

endmodule

// File: rtl/glk_frame_seq.sv
module glk_frame_seq
   import glk_pkg::*;
#(
   parameter int WORD_W  = 23,
   parameter int RST_DLY = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                accept,
   output logic                busy,
   output seg_e                seg,
   output logic                data_step
);
   localparam int FRAME_LEN = frame_len(WORD_W, RST_DLY);
   localparam int POS_W     = $clog2(FRAME_LEN);
   localparam logic [POS_W-1:0] POS_LAST_DATA = POS_W'(WORD_W);
   localparam logic [POS_W-1:0] POS_SLOT      = POS_W'(WORD_W + RST_DLY);

   logic [POS_W-1:0] pos;

   generate
      if (RST_DLY < 1) begin : g_bad_dly
         $error("glk_frame_seq: RST_DLY must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         pos  <= '0;
      end else if (!busy) begin
         if (accept) begin
            busy <= 1'b1;
            pos  <= '0;
         end
      end else if (pos == POS_SLOT) begin
         busy <= 1'b0;
         pos  <= '0;
      end else begin
         pos <= pos + POS_W'(1);
      end
   end

   always_comb begin
      if (pos == '0) begin
         seg = SEG_START;
      end else if (pos <= POS_LAST_DATA) begin
         seg = SEG_DATA;
      end else if (pos < POS_SLOT) begin
         seg = SEG_GUARD;
      end else begin
         seg = SEG_SLOT;
      end
   end

   assign data_step = busy && (seg == SEG_DATA);

endmodule

// File: rtl/glk_word_shifter.sv
module glk_word_shifter #(
   parameter int WORD_W    = 23,
   parameter bit LSB_ZERO  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              step,
   input  logic [WORD_W-1:0] word,
   output logic              bit_o
);
   logic [WORD_W-1:0] shadow;
   logic [WORD_W-1:0] load_val;

   generate
      if (WORD_W < 2) begin : g_bad_w
         $error("glk_word_shifter: WORD_W must be at least 2");
      end
      if (LSB_ZERO) begin : g_lsb_zero
         assign load_val = {word[WORD_W-1:1], 1'b0};
      end else begin : g_lsb_pass
         assign load_val = word;
      end
   endgenerate

   // Shadow copy taken at frame start, shifted out MSB first
   always_ff @(posedge clk) begin
      if (rst) begin
         shadow <= '0;
      end else if (load) begin
         shadow <= load_val;
      end else if (step) begin
         shadow <= {shadow[WORD_W-2:0], 1'b0};
      end
   end

   assign bit_o = shadow[WORD_W-1];

endmodule

// File: rtl/glk_phase_arm.sv
module glk_phase_arm (
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic accept,
   input  logic slot_now,
   output logic live
);
   logic pend;

   // pend collects host requests; live belongs to the frame in flight
   always_ff @(posedge clk) begin
      if (rst) begin
         pend <= 1'b0;
         live <= 1'b0;
      end else if (accept) begin
         live <= pend;
         pend <= req;
      end else begin
         if (slot_now) begin
            live <= 1'b0;
         end
         if (req) begin
            pend <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/glk_serial_tx.sv
module glk_serial_tx
   import glk_pkg::*;
#(
   parameter int WORD_W   = 23,
   parameter int RST_DLY  = 8,
   parameter int GAP_CYC  = 128,
   parameter bit LSB_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] ctl_word,
   input  logic              line_strobe,
   input  logic              phase_req,
   output logic              ser_o,
   output logic              phase_zero_o
);
   logic busy;
   logic ready;
   logic accept;
   logic data_step;
   logic shift_bit;
   logic live;
   logic slot_now;
   seg_e seg;

   assign accept   = line_strobe && ready;
   assign slot_now = busy && (seg == SEG_SLOT);

   glk_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
      .clk   (clk),
      .rst   (rst),
      .busy  (busy),
      .ready (ready)
   );

   glk_frame_seq #(.WORD_W(WORD_W), .RST_DLY(RST_DLY)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .accept    (accept),
      .busy      (busy),
      .seg       (seg),
      .data_step (data_step)
   );

   glk_word_shifter #(.WORD_W(WORD_W), .LSB_ZERO(LSB_ZERO)) u_shift (
      .clk   (clk),
      .rst   (rst),
      .load  (accept),
      .step  (data_step),
      .word  (ctl_word),
      .bit_o (shift_bit)
   );

   glk_phase_arm u_arm (
      .clk      (clk),
      .rst      (rst),
      .req      (phase_req),
      .accept   (accept),
      .slot_now (slot_now),
      .live     (live)
   );

   always_comb begin
      ser_o = 1'b0;
      if (busy) begin
         case (seg)
            SEG_START: ser_o = 1'b1;
            SEG_DATA:  ser_o = shift_bit;
            SEG_GUARD: ser_o = 1'b1;
            SEG_SLOT:  ser_o = !live;
            default:   ser_o = 1'b0;
         endcase
      end
   end

   assign phase_zero_o = slot_now && live;

endmodule

// File: rtl/glk_serial_tx_chk.sv
module glk_serial_tx_chk #(
   parameter int WORD_W  = 23,
   parameter int RST_DLY = 8,
   parameter int GAP_CYC = 128
) (
   input logic clk,
   input logic rst,
   input logic busy,
   input logic ser_o,
   input logic phase_zero_o
);
   localparam int FRAME_LEN = glk_pkg::frame_len(WORD_W, RST_DLY);
   localparam int RUN_W     = $clog2(GAP_CYC + FRAME_LEN + 2);
   localparam logic [RUN_W-1:0] IDLE_SAT = RUN_W'(GAP_CYC + 1);

   logic [RUN_W-1:0] idle_run;
   logic [RUN_W-1:0] busy_run;

   always_ff @(posedge clk) begin
      if (rst || busy) begin
         idle_run <= '0;
      end else if (idle_run != IDLE_SAT) begin
         idle_run <= idle_run + RUN_W'(1);
      end
      if (rst || !busy) begin
         busy_run <= '0;
      end else begin
         busy_run <= busy_run + RUN_W'(1);
      end
   end

   // R1
   idle_low_chk: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (!ser_o && !phase_zero_o));

   // R2
   start_high_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> ser_o);

   // R5
   frame_len_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> (busy_run == RUN_W'(FRAME_LEN)));

   // R6
   pulse_low_chk: assert property (@(posedge clk) disable iff (rst)
      phase_zero_o |-> !ser_o);

   // R6
   pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
      phase_zero_o |=> !phase_zero_o);

   // R7
   gap_min_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> (idle_run >= IDLE_SAT));

endmodule

bind glk_serial_tx glk_serial_tx_chk #(
   .WORD_W  (WORD_W),
   .RST_DLY (RST_DLY),
   .GAP_CYC (GAP_CYC)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .busy         (busy),
   .ser_o        (ser_o),
   .phase_zero_o (phase_zero_o)
);

// File: tb/tb_glk_serial_tx.sv
module tb_glk_serial_tx;
   localparam int W   = 23;
   localparam int GAP = 129;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] ctl_word = '0;
   logic         line_strobe = 1'b0;
   logic         phase_req = 1'b0;
   logic         ser_o;
   logic         phase_zero_o;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   glk_serial_tx dut (
      .clk          (clk),
      .rst          (rst),
      .ctl_word     (ctl_word),
      .line_strobe  (line_strobe),
      .phase_req    (phase_req),
      .ser_o        (ser_o),
      .phase_zero_o (phase_zero_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called at the negedge of an idle cycle; returns at the first idle
   // negedge after the frame.
   task automatic send_frame(input logic [W-1:0] w, input bit exp_arm,
                             input bit chk_gap, input int req_bit, input bit slot_req);
      int gap = 0;
      ctl_word = w;
      line_strobe = 1'b1;
      while (!ser_o && gap < 1000) begin
         gap++;
         @(negedge clk);
      end
      line_strobe = 1'b0;
      if (chk_gap) check(gap == GAP, "R7 idle gap", gap, GAP);
      check(ser_o == 1'b1, "R2 start bit", ser_o, 1);
      check(phase_zero_o == 1'b0, "R2 no pulse at start", phase_zero_o, 0);
      ctl_word = ~w; // R4: must not matter
      for (int i = W - 1; i >= 0; i--) begin
         @(negedge clk);
         phase_req = (req_bit == i);
         check(ser_o == ((i == 0) ? 1'b0 : w[i]), "R3 data bit", ser_o,
               (i == 0) ? 0 : int'(w[i]));
      end
      phase_req = 1'b0;
      for (int g = 0; g < 7; g++) begin
         @(negedge clk);
         check(ser_o == 1'b1, "R5 guard", ser_o, 1);
      end
      @(negedge clk);
      phase_req = slot_req;
      check(ser_o == !exp_arm, "R6 slot level", ser_o, int'(!exp_arm));
      check(phase_zero_o == exp_arm, "R6 pulse", phase_zero_o, int'(exp_arm));
      @(negedge clk);
      phase_req = 1'b0;
      check(ser_o == 1'b0 && phase_zero_o == 1'b0, "R1 idle after frame",
            {ser_o, phase_zero_o}, 0);
   endtask

   task automatic req_pulse();
      phase_req = 1'b1;
      @(negedge clk);
      phase_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic expect_quiet(input int n, input string req);
      int bad = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (ser_o || phase_zero_o) bad++;
      end
      check(bad == 0, req, bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(ser_o == 1'b0, "R1 reset line", ser_o, 0);
      check(phase_zero_o == 1'b0, "R1 reset pulse", phase_zero_o, 0);
      rst = 1'b0;

      // R3 walking ones across every bit position, with gap check (R7)
      for (int i = 0; i < W; i++) send_frame(W'(1) << i, 1'b0, 1'b1, -1, 1'b0);
      send_frame({W{1'b1}}, 1'b0, 1'b1, -1, 1'b0);
      send_frame('0, 1'b0, 1'b1, -1, 1'b0);
      send_frame(23'h2AAAAB, 1'b0, 1'b1, -1, 1'b0);
      send_frame(23'h555554, 1'b0, 1'b1, -1, 1'b0);

      // R8 request in idle arms next frame, then cleared
      req_pulse();
      send_frame(23'h123457, 1'b1, 1'b0, -1, 1'b0);
      send_frame(23'h7FEDC1, 1'b0, 1'b1, -1, 1'b0);

      // R9 request mid-word applies to the following frame
      send_frame(23'h0F0F0F, 1'b0, 1'b1, 10, 1'b0);
      send_frame(23'h70F0F0, 1'b1, 1'b1, -1, 1'b0);
      send_frame(23'h333333, 1'b0, 1'b1, -1, 1'b0);

      // R9 request in the slot cycle of an armed frame
      req_pulse();
      send_frame(23'h1ACE11, 1'b1, 1'b0, -1, 1'b1);
      send_frame(23'h2BEEF3, 1'b1, 1'b1, -1, 1'b0);
      send_frame(23'h600DF0, 1'b0, 1'b1, -1, 1'b0);

      // R7 single early strobe is ignored
      repeat (60) @(negedge clk);
      line_strobe = 1'b1;
      @(negedge clk);
      line_strobe = 1'b0;
      expect_quiet(150, "R7 early strobe ignored");
      send_frame(23'h4C3B2A, 1'b0, 1'b0, -1, 1'b0);

      // R7 strobe held for one cycle short of the gap is ignored
      line_strobe = 1'b1;
      repeat (GAP - 1) @(negedge clk);
      line_strobe = 1'b0;
      expect_quiet(200, "R7 strobe one short of gap");
      send_frame(23'h00ABCD, 1'b0, 1'b0, -1, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule